// File: doc/BRIEF.md
# Branch Decision and Target Unit

This unit resolves every control-transfer command of a small 8-bit microcontroller core. For each decoded command it decides whether the branch is taken, computes the next program counter, reports the instruction length and the clock cycles the command occupies, and, for decrement-then-branch, produces the decremented byte with a write enable aimed at B, C or the short-direct memory byte. The decoder supplies the command code, the operand-space and decrement-target selectors, the bit index, the current PC, the signed displacement and the absolute target. The core supplies the carry and zero flags, the bytes that may hold the tested bit, and the A, X, B and C registers.

Results are registered. A command presented with `valid_i` high appears on the outputs one clock later with `valid_o` high. While `valid_i` is low, the result outputs keep their last values. Instruction length and cycle count are derived from the command form, so the decoder never has to supply them. The carry and zero flags are passed through untouched, because no branch form writes them.

Top module: `br_unit`

## Requirements
- R1: A relative target equals PC + instruction length + sign-extended 8-bit displacement, taken modulo 2^16. The short relative jump (op 1) is always taken and has length 2 and 6 cycles.
- R2: When a conditional branch is not taken, `next_pc_o` equals PC + instruction length, modulo 2^16.
- R3: Op 0 jumps to `abs_i` (length 3, 6 cycles). Op 2 jumps to {A,X}, with A as the high byte (length 1, 6 cycles). Both are always taken.
- R4: Op 3 branches if CY=1, op 4 if CY=0, op 5 if Z=1 and op 6 if Z=0. Each has length 2 and 6 cycles.
- R5: Op 7 branches if the selected bit is 1 and op 8 if it is 0. `space_i` selects the source byte: 0 short-direct byte, 1 special register, 2 accumulator, 3 status word. `bit_sel_i` selects the bit. The accumulator form has length 3 and 8 cycles; the other forms have length 4 and 10 cycles.
- R6: Op 9 decrements the byte selected by `dec_tgt_i` (0 B, 1 C, 2 or 3 short-direct byte) modulo 256 and branches only if the result is nonzero. The result appears on `dec_val_o`. The register forms have length 2 and 6 cycles; the memory form has length 3 and 8 cycles.
- R7: `cy_o` and `z_o` equal the CY and Z of the command, for every op, including a decrement that reaches zero.
- R8: `valid_o` follows `valid_i` one cycle later. While `valid_i` is low, all other outputs hold their values.
- R9: During reset, every output is zero.
- R10: At most one of `wr_b_o`, `wr_c_o`, `wr_mem_o` is high. They are high only for op 9, and they follow the `dec_tgt_i` mapping of R6. For every other op, `dec_val_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Command present |
| op_i | input | 4 | Command code (R1 to R6) |
| space_i | input | 2 | Source of the tested bit |
| dec_tgt_i | input | 2 | Decrement target |
| bit_sel_i | input | 3 | Index of the tested bit |
| pc_i | input | 16 | Current PC |
| disp_i | input | 8 | Signed displacement |
| abs_i | input | 16 | Absolute target |
| cy_i | input | 1 | Carry flag |
| z_i | input | 1 | Zero flag |
| short_i | input | 8 | Short-direct memory byte |
| special_i | input | 8 | Special register byte |
| status_i | input | 8 | Status word |
| a_i | input | 8 | Accumulator A |
| x_i | input | 8 | Register X |
| b_i | input | 8 | Register B |
| c_i | input | 8 | Register C |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Next PC |
| len_o | output | 3 | Instruction length in bytes |
| cycles_o | output | 4 | Clock cycles of the command |
| dec_val_o | output | 8 | Decremented byte |
| wr_b_o | output | 1 | Write `dec_val_o` to B |
| wr_c_o | output | 1 | Write `dec_val_o` to C |
| wr_mem_o | output | 1 | Write `dec_val_o` to the short-direct byte |
| cy_o | output | 1 | Carry flag, unchanged |
| z_o | output | 1 | Zero flag, unchanged |

## Verification
The hardest cases to reach are the ones where the arithmetic wraps. One is a decrement that starts at zero: it yields 0xFF, so the branch is taken. Another is a target that crosses the 64 KiB boundary in either direction. The vector table places the PC at 0xFFFF with a positive displacement, and at 0x0000 with the most negative displacement, to reach both boundary crossings. A further vector uses a memory decrement from zero. The hold and reset behaviour is checked by changing every input while `valid_i` is low, and by pulsing reset in the middle of the run.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [3:0] {
    OP_JMP_ABS  = 4'd0,
    OP_JMP_REL  = 4'd1,
    OP_JMP_IND  = 4'd2,
    OP_BR_CY    = 4'd3,
    OP_BR_NCY   = 4'd4,
    OP_BR_Z     = 4'd5,
    OP_BR_NZ    = 4'd6,
    OP_BIT_SET  = 4'd7,
    OP_BIT_CLR  = 4'd8,
    OP_DEC_BR   = 4'd9
  } br_op_e;

  typedef enum logic [1:0] {
    SPC_SHORT   = 2'd0,
    SPC_SPECIAL = 2'd1,
    SPC_ACC     = 2'd2,
    SPC_STATUS  = 2'd3
  } bit_space_e;

  typedef enum logic [1:0] {
    DEC_B       = 2'd0,
    DEC_C       = 2'd1,
    DEC_MEM     = 2'd2,
    DEC_MEM_ALT = 2'd3
  } dec_tgt_e;

  localparam int unsigned LEN_W = 3;
  localparam int unsigned CYC_W = 4;
endpackage

// File: rtl/br_timing.sv
module br_timing
  import br_pkg::*;
(
  input  br_op_e               op_i,
  input  bit_space_e           space_i,
  input  dec_tgt_e             dec_tgt_i,
  output logic [LEN_W-1:0]     len_o,
  output logic [CYC_W-1:0]     cycles_o
);
  always_comb begin
    len_o    = LEN_W'(1);
    cycles_o = CYC_W'(6);
    unique case (op_i)
      OP_JMP_ABS: begin len_o = LEN_W'(3); cycles_o = CYC_W'(6); end
      OP_JMP_REL: begin len_o = LEN_W'(2); cycles_o = CYC_W'(6); end
      OP_JMP_IND: begin len_o = LEN_W'(1); cycles_o = CYC_W'(6); end
      OP_BR_CY, OP_BR_NCY, OP_BR_Z, OP_BR_NZ: begin
        len_o    = LEN_W'(2);
        cycles_o = CYC_W'(6);
      end
      OP_BIT_SET, OP_BIT_CLR: begin
        if (space_i == SPC_ACC) begin
          len_o    = LEN_W'(3);
          cycles_o = CYC_W'(8);
        end else begin
          len_o    = LEN_W'(4);
          cycles_o = CYC_W'(10);
        end
      end
      OP_DEC_BR: begin
        if (dec_tgt_i == DEC_B || dec_tgt_i == DEC_C) begin
          len_o    = LEN_W'(2);
          cycles_o = CYC_W'(6);
        end else begin
          len_o    = LEN_W'(3);
          cycles_o = CYC_W'(8);
        end
      end
      default: begin
        len_o    = LEN_W'(1);
        cycles_o = CYC_W'(6);
      end
    endcase
  end
endmodule

// File: rtl/br_cond.sv
module br_cond
  import br_pkg::*;
#(
  parameter int unsigned DW    = 8,
  localparam int unsigned SEL_W = $clog2(DW),
  localparam int unsigned N_SPC = 4
) (
  input  br_op_e            op_i,
  input  bit_space_e        space_i,
  input  dec_tgt_e          dec_tgt_i,
  input  logic [SEL_W-1:0]  bit_sel_i,
  input  logic              cy_i,
  input  logic              z_i,
  input  logic [DW-1:0]     short_i,
  input  logic [DW-1:0]     special_i,
  input  logic [DW-1:0]     status_i,
  input  logic [DW-1:0]     acc_i,
  input  logic [DW-1:0]     b_i,
  input  logic [DW-1:0]     c_i,
  output logic              taken_o,
  output logic              rel_o,
  output logic [DW-1:0]     dec_val_o,
  output logic              wr_b_o,
  output logic              wr_c_o,
  output logic              wr_mem_o
);
  logic [DW-1:0]    src [N_SPC];
  logic [N_SPC-1:0] tested;
  logic             bit_val;
  logic [DW-1:0]    dec_src;
  logic [DW-1:0]    dec_new;
  logic             is_dec;

  assign src[SPC_SHORT]   = short_i;
  assign src[SPC_SPECIAL] = special_i;
  assign src[SPC_ACC]     = acc_i;
  assign src[SPC_STATUS]  = status_i;

  for (genvar g = 0; g < N_SPC; g++) begin : g_bit
    assign tested[g] = src[g][bit_sel_i];
  end

  assign bit_val = tested[space_i];

  always_comb begin
    unique case (dec_tgt_i)
      DEC_B:   dec_src = b_i;
      DEC_C:   dec_src = c_i;
      default: dec_src = short_i;
    endcase
  end

  assign dec_new = dec_src - DW'(1);
  assign is_dec  = (op_i == OP_DEC_BR);

  always_comb begin
    taken_o = 1'b0;
    rel_o   = 1'b1;
    unique case (op_i)
      OP_JMP_ABS: begin taken_o = 1'b1; rel_o = 1'b0; end
      OP_JMP_IND: begin taken_o = 1'b1; rel_o = 1'b0; end
      OP_JMP_REL: taken_o = 1'b1;
      OP_BR_CY:   taken_o = cy_i;
      OP_BR_NCY:  taken_o = ~cy_i;
      OP_BR_Z:    taken_o = z_i;
      OP_BR_NZ:   taken_o = ~z_i;
      OP_BIT_SET: taken_o = bit_val;
      OP_BIT_CLR: taken_o = ~bit_val;
      OP_DEC_BR:  taken_o = |dec_new;
      default:    taken_o = 1'b0;
    endcase
  end

  assign dec_val_o = is_dec ? dec_new : '0;
  assign wr_b_o    = is_dec && (dec_tgt_i == DEC_B);
  assign wr_c_o    = is_dec && (dec_tgt_i == DEC_C);
  assign wr_mem_o  = is_dec && (dec_tgt_i == DEC_MEM || dec_tgt_i == DEC_MEM_ALT);
endmodule

// File: rtl/br_target.sv
module br_target
  import br_pkg::*;
#(
  parameter int unsigned PC_W = 16,
  parameter int unsigned DW   = 8
) (
  input  br_op_e             op_i,
  input  logic               taken_i,
  input  logic               rel_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [DW-1:0]      disp_i,
  input  logic [PC_W-1:0]    abs_i,
  input  logic [DW-1:0]      a_i,
  input  logic [DW-1:0]      x_i,
  output logic [PC_W-1:0]    next_pc_o
);
  localparam int unsigned EXT_W = PC_W - DW;

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] rel_pc;
  logic [PC_W-1:0] ind_pc;

  assign seq_pc = pc_i + PC_W'(len_i);
  assign rel_pc = seq_pc + {{EXT_W{disp_i[DW-1]}}, disp_i};
  assign ind_pc = PC_W'({a_i, x_i});

  always_comb begin
    if (!taken_i)                next_pc_o = seq_pc;
    else if (rel_i)              next_pc_o = rel_pc;
    else if (op_i == OP_JMP_IND) next_pc_o = ind_pc;
    else                         next_pc_o = abs_i;
  end
endmodule

// File: rtl/br_unit.sv
module br_unit
  import br_pkg::*;
#(
  parameter int unsigned PC_W = 16,
  parameter int unsigned DW   = 8,
  localparam int unsigned SEL_W = $clog2(DW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        space_i,
  input  logic [1:0]        dec_tgt_i,
  input  logic [SEL_W-1:0]  bit_sel_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DW-1:0]     disp_i,
  input  logic [PC_W-1:0]   abs_i,
  input  logic              cy_i,
  input  logic              z_i,
  input  logic [DW-1:0]     short_i,
  input  logic [DW-1:0]     special_i,
  input  logic [DW-1:0]     status_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     x_i,
  input  logic [DW-1:0]     b_i,
  input  logic [DW-1:0]     c_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [CYC_W-1:0]  cycles_o,
  output logic [DW-1:0]     dec_val_o,
  output logic              wr_b_o,
  output logic              wr_c_o,
  output logic              wr_mem_o,
  output logic              cy_o,
  output logic              z_o
);
  br_op_e     op;
  bit_space_e spc;
  dec_tgt_e   dtgt;

  assign op   = br_op_e'(op_i);
  assign spc  = bit_space_e'(space_i);
  assign dtgt = dec_tgt_e'(dec_tgt_i);

  logic [LEN_W-1:0] len_d;
  logic [CYC_W-1:0] cyc_d;
  logic             taken_d;
  logic             rel_d;
  logic [DW-1:0]    dec_d;
  logic             wr_b_d;
  logic             wr_c_d;
  logic             wr_m_d;
  logic [PC_W-1:0]  npc_d;

  br_timing u_timing (
    .op_i      (op),
    .space_i   (spc),
    .dec_tgt_i (dtgt),
    .len_o     (len_d),
    .cycles_o  (cyc_d)
  );

  br_cond #(.DW(DW)) u_cond (
    .op_i      (op),
    .space_i   (spc),
    .dec_tgt_i (dtgt),
    .bit_sel_i (bit_sel_i),
    .cy_i      (cy_i),
    .z_i       (z_i),
    .short_i   (short_i),
    .special_i (special_i),
    .status_i  (status_i),
    .acc_i     (a_i),
    .b_i       (b_i),
    .c_i       (c_i),
    .taken_o   (taken_d),
    .rel_o     (rel_d),
    .dec_val_o (dec_d),
    .wr_b_o    (wr_b_d),
    .wr_c_o    (wr_c_d),
    .wr_mem_o  (wr_m_d)
  );

  br_target #(.PC_W(PC_W), .DW(DW)) u_target (
    .op_i      (op),
    .taken_i   (taken_d),
    .rel_i     (rel_d),
    .pc_i      (pc_i),
    .len_i     (len_d),
    .disp_i    (disp_i),
    .abs_i     (abs_i),
    .a_i       (a_i),
    .x_i       (x_i),
    .next_pc_o (npc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o   <= 1'b0;
      next_pc_o <= '0;
      len_o     <= '0;
      cycles_o  <= '0;
      dec_val_o <= '0;
      wr_b_o    <= 1'b0;
      wr_c_o    <= 1'b0;
      wr_mem_o  <= 1'b0;
      cy_o      <= 1'b0;
      z_o       <= 1'b0;
    end else if (valid_i) begin
      taken_o   <= taken_d;
      next_pc_o <= npc_d;
      len_o     <= len_d;
      cycles_o  <= cyc_d;
      dec_val_o <= dec_d;
      wr_b_o    <= wr_b_d;
      wr_c_o    <= wr_c_d;
      wr_mem_o  <= wr_m_d;
      cy_o      <= cy_i;
      z_o       <= z_i;
    end
  end
endmodule

// File: rtl/br_unit_chk.sv
module br_unit_chk
  import br_pkg::*;
#(
  parameter int unsigned PC_W = 16,
  parameter int unsigned DW   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [PC_W-1:0]   pc_i,
  input logic              cy_i,
  input logic              z_i,
  input logic              valid_o,
  input logic              taken_o,
  input logic [PC_W-1:0]   next_pc_o,
  input logic [LEN_W-1:0]  len_o,
  input logic [CYC_W-1:0]  cycles_o,
  input logic [DW-1:0]     dec_val_o,
  input logic              wr_b_o,
  input logic              wr_c_o,
  input logic              wr_mem_o,
  input logic              cy_o,
  input logic              z_o
);
  // R8
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(next_pc_o) && $stable(taken_o) && $stable(cycles_o)));

  // R2
  not_taken_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i ##1 (valid_o && !taken_o)) |-> next_pc_o == ($past(pc_i) + PC_W'(len_o)));

  // R10
  one_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_b_o, wr_c_o, wr_mem_o}));

  // R6
  dec_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (wr_b_o || wr_c_o || wr_mem_o)) |-> (taken_o == (dec_val_o != '0)));

  // R7
  flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (cy_o == $past(cy_i) && z_o == $past(z_i)));

  // R5
  cycle_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cycles_o == 4'd6 || cycles_o == 4'd8 || cycles_o == 4'd10));
endmodule

bind br_unit br_unit_chk #(.PC_W(PC_W), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .pc_i      (pc_i),
  .cy_i      (cy_i),
  .z_i       (z_i),
  .valid_o   (valid_o),
  .taken_o   (taken_o),
  .next_pc_o (next_pc_o),
  .len_o     (len_o),
  .cycles_o  (cycles_o),
  .dec_val_o (dec_val_o),
  .wr_b_o    (wr_b_o),
  .wr_c_o    (wr_c_o),
  .wr_mem_o  (wr_mem_o),
  .cy_o      (cy_o),
  .z_o       (z_o)
);

// File: tb/br_unit_bench.sv
module br_unit_bench;
  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  spc;
    logic [1:0]  dt;
    logic [2:0]  bs;
    logic [15:0] pc;
    logic [7:0]  disp;
    logic [15:0] absa;
    logic        cy;
    logic        z;
    logic [7:0]  sad;
    logic [7:0]  sfr;
    logic [7:0]  psw;
    logic [7:0]  acc;
    logic [7:0]  x;
    logic [7:0]  b;
    logic [7:0]  c;
    logic        tk;
    logic [15:0] npc;
    logic [2:0]  len;
    logic [3:0]  cyc;
    logic [7:0]  dec;
    logic [2:0]  we;
  } vec_t;

  localparam int N = 18;
  localparam vec_t TBL [N] = '{
    // R3 absolute
    '{4'd0,2'd0,2'd0,3'd0,16'h1000,8'h00,16'h2345,1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,1'b1,16'h2345,3'd3,4'd6,8'h00,3'b000},
    // R1 relative forward / backward
    '{4'd1,2'd0,2'd0,3'd0,16'h1000,8'h10,16'h0000,1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,1'b1,16'h1012,3'd2,4'd6,8'h00,3'b000},
    '{4'd1,2'd0,2'd0,3'd0,16'h1000,8'hF0,16'h0000,1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,1'b1,16'h0FF2,3'd2,4'd6,8'h00,3'b000},
    // R3 indirect
    '{4'd2,2'd0,2'd0,3'd0,16'h1000,8'h00,16'h0000,1'b0,1'b0,8'h00,8'h00,8'h00,8'hAB,8'hCD,8'h00,8'h00,1'b1,16'hABCD,3'd1,4'd6,8'h00,3'b000},
    // R4 flag branches
    '{4'd3,2'd0,2'd0,3'd0,16'h1000,8'h05,16'h0000,1'b1,1'b0,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,1'b1,16'h1007,3'd2,4'd6,8'h00,3'b000},
    '{4'd3,2'd0,2'd0,3'd0,16'h1000,8'h05,16'h0000,1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,1'b0,16'h1002,3'd2,4'd6,8'h00,3'b000},
    '{4'd4,2'd0,2'd0,3'd0,16'h1000,8'h05,16'h0000,1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,1'b1,16'h1007,3'd2,4'd6,8'h00,3'b000},
    '{4'd5,2'd0,2'd0,3'd0,16'h1000,8'h80,16'h0000,1'b0,1'b1,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,1'b1,16'h0F82,3'd2,4'd6,8'h00,3'b000},
    '{4'd6,2'd0,2'd0,3'd0,16'h1000,8'h05,16'h0000,1'b0,1'b1,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,1'b0,16'h1002,3'd2,4'd6,8'h00,3'b000},
    // R5 bit branches on each space
    '{4'd7,2'd0,2'd0,3'd3,16'h1000,8'h04,16'h0000,1'b0,1'b0,8'h08,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,1'b1,16'h1008,3'd4,4'd10,8'h00,3'b000},
    '{4'd7,2'd1,2'd0,3'd7,16'h1000,8'h04,16'h0000,1'b0,1'b0,8'hFF,8'h7F,8'h00,8'h00,8'h00,8'h00,8'h00,1'b0,16'h1004,3'd4,4'd10,8'h00,3'b000},
    '{4'd8,2'd2,2'd0,3'd0,16'h1000,8'h02,16'h0000,1'b0,1'b0,8'h00,8'h00,8'h00,8'hFE,8'h00,8'h00,8'h00,1'b1,16'h1005,3'd3,4'd8,8'h00,3'b000},
    '{4'd8,2'd3,2'd0,3'd6,16'h1000,8'h02,16'h0000,1'b0,1'b0,8'h00,8'h00,8'h40,8'h00,8'h00,8'h00,8'h00,1'b0,16'h1004,3'd4,4'd10,8'h00,3'b000},
    // R6 decrement forms
    '{4'd9,2'd0,2'd0,3'd0,16'h1000,8'hFE,16'h0000,1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,8'h00,8'h02,8'h00,1'b1,16'h1000,3'd2,4'd6,8'h01,3'b100},
    '{4'd9,2'd0,2'd1,3'd0,16'h1000,8'hFE,16'h0000,1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h01,1'b0,16'h1002,3'd2,4'd6,8'h00,3'b010},
    '{4'd9,2'd0,2'd2,3'd0,16'h1000,8'h10,16'h0000,1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,1'b1,16'h1013,3'd3,4'd8,8'hFF,3'b001},
    // R1 wrap both ways
    '{4'd1,2'd0,2'd0,3'd0,16'hFFFF,8'h7F,16'h0000,1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,1'b1,16'h0080,3'd2,4'd6,8'h00,3'b000},
    '{4'd7,2'd2,2'd0,3'd5,16'h0000,8'h80,16'h0000,1'b0,1'b0,8'h00,8'h00,8'h00,8'h20,8'h00,8'h00,8'h00,1'b1,16'hFF83,3'd3,4'd8,8'h00,3'b000}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  space_i = '0;
  logic [1:0]  dec_tgt_i = '0;
  logic [2:0]  bit_sel_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  disp_i = '0;
  logic [15:0] abs_i = '0;
  logic        cy_i = 1'b0;
  logic        z_i = 1'b0;
  logic [7:0]  short_i = '0;
  logic [7:0]  special_i = '0;
  logic [7:0]  status_i = '0;
  logic [7:0]  a_i = '0;
  logic [7:0]  x_i = '0;
  logic [7:0]  b_i = '0;
  logic [7:0]  c_i = '0;
  logic        valid_o;
  logic        taken_o;
  logic [15:0] next_pc_o;
  logic [2:0]  len_o;
  logic [3:0]  cycles_o;
  logic [7:0]  dec_val_o;
  logic        wr_b_o;
  logic        wr_c_o;
  logic        wr_mem_o;
  logic        cy_o;
  logic        z_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  br_unit u_br_unit (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .space_i(space_i), .dec_tgt_i(dec_tgt_i), .bit_sel_i(bit_sel_i),
    .pc_i(pc_i), .disp_i(disp_i), .abs_i(abs_i), .cy_i(cy_i), .z_i(z_i),
    .short_i(short_i), .special_i(special_i), .status_i(status_i),
    .a_i(a_i), .x_i(x_i), .b_i(b_i), .c_i(c_i),
    .valid_o(valid_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
    .len_o(len_o), .cycles_o(cycles_o), .dec_val_o(dec_val_o),
    .wr_b_o(wr_b_o), .wr_c_o(wr_c_o), .wr_mem_o(wr_mem_o),
    .cy_o(cy_o), .z_o(z_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    valid_i   = vld;
    op_i      = v.op;
    space_i   = v.spc;
    dec_tgt_i = v.dt;
    bit_sel_i = v.bs;
    pc_i      = v.pc;
    disp_i    = v.disp;
    abs_i     = v.absa;
    cy_i      = v.cy;
    z_i       = v.z;
    short_i   = v.sad;
    special_i = v.sfr;
    status_i  = v.psw;
    a_i       = v.acc;
    x_i       = v.x;
    b_i       = v.b;
    c_i       = v.c;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "outputs in reset",
          {12'd0, valid_o, taken_o, next_pc_o, wr_b_o, wr_c_o, wr_mem_o},
          32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N; i++) begin
      drive(TBL[i], 1'b1);
      @(negedge clk);
      check("R8", "valid_o", {31'd0, valid_o}, 32'd1);
      check("R1/R2/R3/R4/R5/R6 taken", $sformatf("vec %0d taken", i), {31'd0, taken_o}, {31'd0, TBL[i].tk});
      check("R1/R2/R3/R4/R5/R6 next_pc", $sformatf("vec %0d next_pc", i), {16'd0, next_pc_o}, {16'd0, TBL[i].npc});
      check("R3/R4/R5/R6 len", $sformatf("vec %0d len", i), {29'd0, len_o}, {29'd0, TBL[i].len});
      check("R3/R4/R5/R6 cycles", $sformatf("vec %0d cycles", i), {28'd0, cycles_o}, {28'd0, TBL[i].cyc});
      check("R6 dec", $sformatf("vec %0d dec_val", i), {24'd0, dec_val_o}, {24'd0, TBL[i].dec});
      check("R10 we", $sformatf("vec %0d write enables", i), {29'd0, wr_b_o, wr_c_o, wr_mem_o}, {29'd0, TBL[i].we});
    end

    // R7: decrement reaching zero leaves flags as given
    v = TBL[14];
    v.cy = 1'b1;
    v.z  = 1'b0;
    drive(v, 1'b1);
    @(negedge clk);
    check("R7", "cy_o after dec to zero", {31'd0, cy_o}, 32'd1);
    check("R7", "z_o after dec to zero", {31'd0, z_o}, 32'd0);

    // R8: inputs change while valid_i low, outputs hold
    v = TBL[0];
    drive(v, 1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R8", "valid_o low", {31'd0, valid_o}, 32'd0);
    check("R8", "next_pc held", {16'd0, next_pc_o}, 32'h1002);
    check("R8", "cy_o held", {31'd0, cy_o}, 32'd1);
    check("R8", "wr_c_o held", {31'd0, wr_c_o}, 32'd1);

    // R9: reset in mid-run
    drive(TBL[3], 1'b1);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R9", "next_pc after reset", {16'd0, next_pc_o}, 32'd0);
    check("R9", "taken/valid after reset", {30'd0, taken_o, valid_o}, 32'd0);
    check("R9", "len/cycles after reset", {25'd0, len_o, cycles_o}, 32'd0);
    valid_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R10: decrement target code 3 selects memory
    v = TBL[15];
    v.dt = 2'd3;
    v.sad = 8'h05;
    drive(v, 1'b1);
    @(negedge clk);
    check("R10", "alt memory target we", {29'd0, wr_b_o, wr_c_o, wr_mem_o}, 32'd1);
    check("R6", "alt memory dec value", {24'd0, dec_val_o}, 32'h04);
    valid_i = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule